// File: doc/BRIEF.md
# Reverse-Order Framed CRC-16 Engine

This block computes a 16-bit CRC with generator x^16+x^12+x^5+1 (0x1021), register cleared to zero, no reflection and no final inversion. The message reaches it in the opposite order from the one the CRC is defined over. Bytes come in frames of up to seven slots. The first slot of the first frame is the least significant byte of the message. The result must match the CRC computed in the usual way, with the most significant byte first.

The block never buffers or re-orders the message. It keeps a running CRC and a multiplier that holds x^(8k+8) modulo the polynomial. Each arriving byte is multiplied by the next power of x^8 modulo the polynomial, using carryless arithmetic, and XORed into the running CRC. A frame is taken over a valid/ready handshake. The block then folds one byte per clock and holds ready low until the frame is finished. A start flag on a frame begins a new message. A last flag, together with a byte count, closes the message and raises a one-cycle done strobe.

Top module: `rev_crc16_frame`

## Requirements
- R1: When a message ends, crcOut equals the CRC-16 (polynomial 0x1021, initial value 0, no reflection, no output XOR) of the message bytes taken in the reverse of their arrival order.
- R2: Slot k of a frame sits in inData[8k+7:8k]. Slot 0 is the earliest byte of the frame, and slots are consumed in increasing order, one per clock.
- R3: A frame accepted with inLast low folds all seven slots, whatever value inCount carries.
- R4: A frame accepted with inLast high folds only slots 0 to inCount-1. Bytes in the higher slots do not change the result.
- R5: On a last frame, an inCount of 0 is treated as a full frame of seven bytes.
- R6: A frame accepted with inStart high first clears the CRC to zero and the multiplier to 0x100, so no earlier frame affects the new message. A frame without inStart continues the current message.
- R7: After a frame with n folded bytes is accepted, inFrameReady is low for exactly n clocks and then returns high.
- R8: crcDone is high for exactly one clock, n clocks after the acceptance of a last frame with n folded bytes, together with the final crcOut. crcOut then holds its value until another byte is folded.
- R9: A frame offered while the block is busy is held off by inFrameReady and is taken later without loss.
- R10: After reset, inFrameReady is 1, crcDone is 0 and crcOut is 0.
- R11: The digits "123456789", arriving as 0x39 first through 0x31 last, give 0x31C3. The 18-byte value 0x4376669A1CFC048321313233343536373839, arriving least significant byte first in three frames, gives 0x2848.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inFrameValid | input | 1 | A frame is offered |
| inFrameReady | output | 1 | The block can take a frame this clock |
| inData | input | 56 | Seven byte slots; slot k in bits 8k+7:8k |
| inCount | input | 3 | Number of valid slots in a last frame (0 means 7) |
| inStart | input | 1 | This frame begins a new message |
| inLast | input | 1 | This frame ends the message |
| crcOut | output | 16 | Running and final CRC |
| crcDone | output | 1 | One-clock strobe: crcOut holds the finished CRC |

## Verification
The hardest situation to reach is a frame arriving while the previous one is still being folded. Reaching it requires keeping valid high across several clocks of ready-low without the frame being lost or taken twice. The bench presents every frame of a message back to back: it raises valid for the next frame on the clock right after the previous acceptance, so each later frame sits in the held-off state for the full busy window. Messages of many lengths exercise all partial last-frame counts, including the count-of-zero case. Garbage is placed in unused slots and in the count field of non-last frames to show that it is ignored.

// File: rtl/rcrc_pkg.sv
package rcrc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture the offered frame
    logic clear;   // begin a new message
    logic fold;    // fold the selected slot this clock
    logic finish;  // this fold completes the message
  } crcStrobes_t;

endpackage

// File: rtl/rcrc_ctl.sv
module rcrc_ctl
  import rcrc_pkg::*;
#(
  parameter int FRAME_BYTES = 7,
  localparam int SLOT_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1,
  localparam int CNT_W  = $clog2(FRAME_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inFrameValid,
  output logic              inFrameReady,
  input  logic [CNT_W-1:0]  inCount,
  input  logic              inStart,
  input  logic              inLast,
  output crcStrobes_t       strobes,
  output logic [SLOT_W-1:0] slotIdx
);

  ctlState_e         state;
  logic [SLOT_W-1:0] lastIdx;
  logic              isLast;
  logic              accept;
  logic [CNT_W-1:0]  effCount;
  logic [SLOT_W-1:0] lastIdxNext;
  logic              atEnd;

  assign inFrameReady = (state == ST_IDLE);
  assign accept       = inFrameValid && inFrameReady;

  always_comb begin
    if (!inLast || inCount == '0 || inCount > CNT_W'(FRAME_BYTES)) begin
      effCount = CNT_W'(FRAME_BYTES);
    end else begin
      effCount = inCount;
    end
    lastIdxNext = SLOT_W'(effCount - CNT_W'(1));
  end

  assign atEnd = (slotIdx == lastIdx);

  always_comb begin
    strobes        = '0;
    strobes.load   = accept;
    strobes.clear  = accept && inStart;
    strobes.fold   = (state == ST_BUSY);
    strobes.finish = (state == ST_BUSY) && atEnd && isLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slotIdx <= '0;
      lastIdx <= '0;
      isLast  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_BUSY;
            slotIdx <= '0;
            lastIdx <= lastIdxNext;
            isLast  <= inLast;
          end
        end
        ST_BUSY: begin
          if (atEnd) begin
            state <= ST_IDLE;
          end else begin
            slotIdx <= slotIdx + SLOT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> (slotIdx <= lastIdx && 32'(lastIdx) < FRAME_BYTES)); // R2

  AST_FULL_NONLAST: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !inLast) |=> (32'(lastIdx) == FRAME_BYTES - 1)); // R3

endmodule

// File: rtl/rcrc_dp.sv
module rcrc_dp
  import rcrc_pkg::*;
#(
  parameter int          FRAME_BYTES = 7,
  parameter int          CRC_W       = 16,
  parameter logic [15:0] POLY        = 16'h1021,
  localparam int SLOT_W  = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1,
  localparam int BYTE_W  = 8,
  localparam int FRAME_W = FRAME_BYTES * BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  crcStrobes_t        strobes,
  input  logic [SLOT_W-1:0]  slotIdx,
  input  logic [FRAME_W-1:0] inData,
  output logic [CRC_W-1:0]   crcOut,
  output logic               crcDone
);

  localparam logic [CRC_W-1:0] POLY_W    = CRC_W'(POLY);
  localparam logic [CRC_W-1:0] MULT_INIT = CRC_W'(1) << BYTE_W;

  // multiply by x modulo the generator
  function automatic logic [CRC_W-1:0] timesX(input logic [CRC_W-1:0] v);
    return v[CRC_W-1] ? ((v << 1) ^ POLY_W) : (v << 1);
  endfunction

  // multiply a reduced value by x^8 modulo the generator
  function automatic logic [CRC_W-1:0] timesX8(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] acc;
    acc = v;
    for (int i = 0; i < BYTE_W; i++) acc = timesX(acc);
    return acc;
  endfunction

  // carryless byte times reduced value, modulo the generator (Horner form)
  function automatic logic [CRC_W-1:0] mulByte(input logic [CRC_W-1:0] m,
                                               input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] acc;
    acc = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      acc = timesX(acc);
      if (b[i]) acc = acc ^ m;
    end
    return acc;
  endfunction

  logic [FRAME_W-1:0] frameReg;
  logic [BYTE_W-1:0]  slotBytes [FRAME_BYTES];
  logic [BYTE_W-1:0]  curByte;
  logic [CRC_W-1:0]   crcReg;
  logic [CRC_W-1:0]   multReg;
  logic [CRC_W-1:0]   multNext;
  logic [CRC_W-1:0]   termNext;

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_slot
    assign slotBytes[g] = frameReg[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    curByte = '0;
    for (int k = 0; k < FRAME_BYTES; k++) begin
      if (32'(slotIdx) == k) curByte = slotBytes[k];
    end
    multNext = timesX8(multReg);
    termNext = mulByte(multNext, curByte);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
      crcReg   <= '0;
      multReg  <= MULT_INIT;
      crcDone  <= 1'b0;
    end else begin
      crcDone <= strobes.finish;
      if (strobes.load) frameReg <= inData;
      if (strobes.clear) begin
        crcReg  <= '0;
        multReg <= MULT_INIT;
      end else if (strobes.fold) begin
        crcReg  <= crcReg ^ termNext;
        multReg <= multNext;
      end
    end
  end

  assign crcOut = crcReg;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (crcOut == '0)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.fold && !strobes.clear) |=> $stable(crcOut)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    crcDone |=> !crcDone); // R8

  AST_DONE_AFTER_FOLD: assert property (@(posedge clk) disable iff (!rstN)
    crcDone |-> $past(strobes.fold)); // R8

endmodule

// File: rtl/rev_crc16_frame.sv
module rev_crc16_frame
  import rcrc_pkg::*;
#(
  parameter int          FRAME_BYTES = 7,
  parameter int          CRC_W       = 16,
  parameter logic [15:0] POLY        = 16'h1021,
  localparam int SLOT_W  = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1,
  localparam int CNT_W   = $clog2(FRAME_BYTES + 1),
  localparam int FRAME_W = FRAME_BYTES * 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inFrameValid,
  output logic               inFrameReady,
  input  logic [FRAME_W-1:0] inData,
  input  logic [CNT_W-1:0]   inCount,
  input  logic               inStart,
  input  logic               inLast,
  output logic [CRC_W-1:0]   crcOut,
  output logic               crcDone
);

  crcStrobes_t       strobes;
  logic [SLOT_W-1:0] slotIdx;

  rcrc_ctl #(.FRAME_BYTES(FRAME_BYTES)) ctl_i (
    .clk          (clk),
    .rstN         (rstN),
    .inFrameValid (inFrameValid),
    .inFrameReady (inFrameReady),
    .inCount      (inCount),
    .inStart      (inStart),
    .inLast       (inLast),
    .strobes      (strobes),
    .slotIdx      (slotIdx)
  );

  rcrc_dp #(.FRAME_BYTES(FRAME_BYTES), .CRC_W(CRC_W), .POLY(POLY)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .slotIdx (slotIdx),
    .inData  (inData),
    .crcOut  (crcOut),
    .crcDone (crcDone)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (inFrameValid && inFrameReady) |=> !inFrameReady); // R7

  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    crcDone |-> inFrameReady); // R8

endmodule

// File: tb/rev_crc16_frame_tb_top.sv
`timescale 1ns/1ps
module rev_crc16_frame_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inFrameValid = 1'b0;
  logic        inFrameReady;
  logic [55:0] inData = '0;
  logic [2:0]  inCount = '0;
  logic        inStart = 1'b0;
  logic        inLast = 1'b0;
  logic [15:0] crcOut;
  logic        crcDone;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0]  msg [0:63];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  rev_crc16_frame dut_i (
    .clk (clk), .rstN (rstN),
    .inFrameValid (inFrameValid), .inFrameReady (inFrameReady),
    .inData (inData), .inCount (inCount),
    .inStart (inStart), .inLast (inLast),
    .crcOut (crcOut), .crcDone (crcDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // plain forward CRC over the message in reverse arrival order
  function automatic logic [15:0] refCrc(input int n);
    logic [15:0] c;
    c = '0;
    for (int i = n - 1; i >= 0; i--) begin
      c = c ^ {msg[i], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [7:0] nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[7:0] ^ lfsr[23:16];
  endfunction

  // offer one frame (called at a falling edge) and return at the falling edge after acceptance
  task automatic sendFrame(input logic [55:0] d, input logic [2:0] cnt,
                           input bit st, input bit lst);
    bit r;
    inData = d; inCount = cnt; inStart = st; inLast = lst; inFrameValid = 1'b1;
    do begin
      r = inFrameReady;
      @(posedge clk); @(negedge clk);
    end while (!r);
    inFrameValid = 1'b0;
  endtask

  // send msg[0:n-1] back to back; optional junk in unused slots; zeroCount sends 0 for a full last frame
  task automatic sendMsg(input int n, input bit zeroCount, input logic [15:0] fixedExp,
                         input bit useFixed, input string tag);
    int frames, lastN, k, lowReady;
    logic [55:0] d;
    logic [15:0] expv, held;
    frames = (n + 6) / 7;
    for (int f = 0; f < frames; f++) begin
      for (int s = 0; s < 7; s++)
        d[s*8 +: 8] = (f*7 + s < n) ? msg[f*7 + s] : nextRand();
      if (f == frames - 1) begin
        lastN = n - f*7;
        sendFrame(d, (lastN == 7 && zeroCount) ? 3'd0 : 3'(lastN), f == 0, 1'b1);
      end else begin
        sendFrame(d, 3'(2), f == 0, 1'b0); // R3: count garbage on non-last frame
      end
    end
    k = 0; lowReady = 0;
    while (!crcDone && k < 40) begin
      if (!inFrameReady) lowReady++;
      @(posedge clk); @(negedge clk);
      k++;
    end
    expv = useFixed ? fixedExp : refCrc(n);
    check(crcOut == expv, {"R1/R4/R9 crc ", tag}, crcOut, expv);
    check(k == lastN, "R8 done latency", k, lastN);
    check(lowReady == lastN && inFrameReady, "R7 ready low window", lowReady, lastN);
    held = crcOut;
    @(posedge clk); @(negedge clk);
    check(!crcDone, "R8 done single pulse", crcDone, 0);
    check(crcOut == held, "R8 crc holds", crcOut, held);
  endtask

  task automatic testReset();
    check(inFrameReady == 1'b1, "R10 ready after reset", inFrameReady, 1);
    check(crcDone == 1'b0, "R10 done after reset", crcDone, 0);
    check(crcOut == 16'h0, "R10 crc after reset", crcOut, 0);
  endtask

  task automatic testDigits();
    for (int i = 0; i < 9; i++) msg[i] = 8'h39 - 8'(i);
    sendMsg(9, 1'b0, 16'h31C3, 1'b1, "R11 digits"); // R2 slot order
  endtask

  task automatic testLong();
    logic [7:0] v [0:17];
    v = '{8'h39,8'h38,8'h37,8'h36,8'h35,8'h34,8'h33,8'h32,8'h31,
          8'h21,8'h83,8'h04,8'hFC,8'h1C,8'h9A,8'h66,8'h76,8'h43};
    for (int i = 0; i < 18; i++) msg[i] = v[i];
    sendMsg(18, 1'b0, 16'h2848, 1'b1, "R11 eighteen"); // R4 junk in slots 4..6, R9 held frames
  endtask

  task automatic testSingle();
    msg[0] = 8'hA7;
    sendMsg(1, 1'b0, 16'h0, 1'b0, "single byte R4");
  endtask

  task automatic testZeroCount();
    for (int i = 0; i < 14; i++) msg[i] = nextRand();
    sendMsg(14, 1'b1, 16'h0, 1'b0, "R5 count zero");
  endtask

  task automatic testRestart();
    logic [55:0] junk;
    for (int s = 0; s < 7; s++) junk[s*8 +: 8] = nextRand();
    sendFrame(junk, 3'd7, 1'b1, 1'b0); // abandoned message
    for (int i = 0; i < 10; i++) msg[i] = nextRand();
    sendMsg(10, 1'b0, 16'h0, 1'b0, "R6 restart");
  endtask

  task automatic testRandom();
    for (int t = 1; t <= 30; t++) begin
      for (int i = 0; i < t; i++) msg[i] = nextRand();
      sendMsg(t, t[0], 16'h0, 1'b0, "random R1");
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDigits();
    testLong();
    testSingle();
    testZeroCount();
    testRestart();
    testRandom();
    finish();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish();
  end

endmodule